// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets synchronous logic read and write an external 8K x 8 asynchronous static RAM. A client presents one request at a time (address, write data and a write flag) with a valid/ready handshake. The block latches the request and drives the memory's control pins: two chip selects of opposite polarity, an active-low output enable and an active-low write strobe. It also drives the data lines through a separate driver-enable. For a read, it returns the sampled byte with a one-cycle response strobe.

The memory has no clock, so every access window is produced by counting cycles of the system clock. Nanosecond limits for the chosen speed grade are converted to whole cycles at elaboration, using the clock period parameter and rounding up. The three limits are cycle time, address-to-data time and output-enable-to-data time. After every read, the block waits for the memory to stop driving the shared data lines before it drives them itself. Between accesses, the memory is left deselected so that it draws standby current only.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever the block is idle, `req_ready` is 1, `mem_ce1_n` is 1, `mem_ce2` is 0, `mem_oe_n` is 1, `mem_we_n` is 1 and `mem_dq_oe` is 0.
- R2: A read holds the chip selected (`mem_ce1_n`=0, `mem_ce2`=1), with `mem_we_n`=1, `mem_dq_oe`=0 and `mem_oe_n`=0, for exactly RD cycles. RD is the largest of the cycle counts for cycle time, address-to-data time and output-enable-to-data time.
- R3: The read byte is sampled from `mem_dq_i` on the clock edge that closes the read window. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, which is the first cycle after the window.
- R4: A write holds the chip selected with `mem_oe_n`=1 and `mem_we_n`=0 for exactly WR cycles, where WR is the cycle count for cycle time. `mem_dq_oe` is 1 and `mem_dq_o` carries the request data for that whole time.
- R5: After `mem_we_n` rises, the block holds address, data and `mem_dq_oe`=1 for one more cycle. `mem_dq_oe` is 1 only during a write or its hold cycle.
- R6: After `mem_oe_n` rises at the end of a read, the chip is deselected and `mem_dq_oe` stays 0 for HZ cycles, the cycle count for bus-release time. This holds even when the next request is already waiting.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 for RD+HZ cycles after a read and for WR+1 cycles after a write.
- R8: Each nanosecond limit is converted with cycles = max(1, ceil(ns / CLK_PERIOD_NS)). `SPEED_GRADE` selects the limits as follows:
  - Grade 0: cycle and access time 15 ns, output-enable-to-data 7 ns, release 6 ns.
  - Grade 1: 20, 8 and 7 ns.
  - Grade 2: 25, 12 and 9 ns.
- R9: `mem_addr` and the driven write data come from the values latched at acceptance. Changes on `req_addr` and `req_wdata` during an access do not reach the pins.
- R10: Read data comes from the addressed location. A byte written to one address is returned by a later read of that address and is not disturbed by writes to other addresses, including addresses 0 and 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 13 | Memory address lines |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable of the data-line driver |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
The hardest case to reach is a write request that is already waiting when a read ends. This is the only moment when the controller's driver could collide with the memory's output, which is still releasing the data lines. The bench keeps `req_valid` high across a read and swaps in write fields right after acceptance. A monitor then counts cycles since `mem_oe_n` rose and flags any driver enable inside the release window. The bench's memory model returns a junk byte until the address-to-data count has elapsed, so a read window that is one cycle short returns the wrong data.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_TURN  = 3'd2,
        ST_WRITE = 3'd3,
        ST_HOLD  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_OFF = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    // Minimum cycle time; the maximum address-to-data time has the same value.
    function automatic int grade_cycle_ns(input int grade);
        case (grade)
            0:       return 15;
            1:       return 20;
            default: return 25;
        endcase
    endfunction

    function automatic int grade_oe_ns(input int grade);
        case (grade)
            0:       return 7;
            1:       return 8;
            default: return 12;
        endcase
    endfunction

    function automatic int grade_release_ns(input int grade);
        case (grade)
            0:       return 6;
            1:       return 7;
            default: return 9;
        endcase
    endfunction

    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_ctl_t pins_for(input seq_state_e st);
        pin_ctl_t p;
        p = PINS_OFF;
        case (st)
            ST_READ: begin
                p.ce1_n = 1'b0;
                p.ce2   = 1'b1;
                p.oe_n  = 1'b0;
            end
            ST_WRITE: begin
                p.ce1_n = 1'b0;
                p.ce2   = 1'b1;
                p.we_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            ST_HOLD: begin
                p.ce1_n = 1'b0;
                p.ce2   = 1'b1;
                p.dq_oe = 1'b1;
            end
            default: p = PINS_OFF;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import asram_ctl_pkg::*;
#(
    parameter int CW      = 2,
    parameter int RD_LOAD = 0,
    parameter int WR_LOAD = 0,
    parameter int HZ_LOAD = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          t_zero,
    output logic          t_load,
    output logic [CW-1:0] t_val,
    output logic          accept,
    output logic          capture,
    output logic          idle,
    output pin_ctl_t      pins
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        accept  = 1'b0;
        capture = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    t_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WRITE;
                        t_val   = CW'(WR_LOAD);
                    end else begin
                        state_d = ST_READ;
                        t_val   = CW'(RD_LOAD);
                    end
                end
            end
            ST_READ: begin
                if (t_zero) begin
                    capture = 1'b1;
                    t_load  = 1'b1;
                    t_val   = CW'(HZ_LOAD);
                    state_d = ST_TURN;
                end
            end
            ST_TURN:  if (t_zero) state_d = ST_IDLE;
            ST_WRITE: if (t_zero) state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign idle = (state_q == ST_IDLE);
    assign pins = pins_for(state_q);
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] dq_i,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rsp_rdata <= dq_i;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int CYC_RC  = ns_to_cycles(grade_cycle_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int CYC_OE  = ns_to_cycles(grade_oe_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int CYC_HZ  = ns_to_cycles(grade_release_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int CYC_RD  = max_int(CYC_RC, CYC_OE);
    localparam int CYC_WR  = CYC_RC;
    localparam int CYC_MAX = max_int(max_int(CYC_RD, CYC_WR), CYC_HZ);
    localparam int CNT_W   = (CYC_MAX < 2) ? 1 : $clog2(CYC_MAX);

    logic             t_load, t_zero, accept, capture, idle;
    logic [CNT_W-1:0] t_val;
    pin_ctl_t         pins;

    sram_wait_timer #(.CW(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    sram_seq_fsm #(
        .CW      (CNT_W),
        .RD_LOAD (CYC_RD - 1),
        .WR_LOAD (CYC_WR - 1),
        .HZ_LOAD (CYC_HZ - 1)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .t_zero    (t_zero),
        .t_load    (t_load),
        .t_val     (t_val),
        .accept    (accept),
        .capture   (capture),
        .idle      (idle),
        .pins      (pins)
    );

    sram_req_latch #(.AW(ADDR_W), .DW(DATA_W)) latch_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_i      (mem_dq_i),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_o),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign req_ready = idle;
    assign mem_ce1_n = pins.ce1_n;
    assign mem_ce2   = pins.ce2;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.dq_oe;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe));

    assert_read_pins_R2: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce1_n && mem_ce2 && mem_we_n && !mem_dq_oe));

    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_write_pins_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce1_n && mem_ce2));

    assert_write_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)));

    assert_release_gap_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |=> !mem_dq_oe);

    assert_accept_only_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(req_ready) |-> $past(req_valid));

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;
    localparam int CLK_NS = 20;
    localparam int GRADE  = 2;
    // Bench-side expectations for grade 2 at 20 ns: 25/25/12/9 ns limits.
    localparam int RD_EXP = (25 + CLK_NS - 1) / CLK_NS;
    localparam int WR_EXP = (25 + CLK_NS - 1) / CLK_NS;
    localparam int HZ_EXP = (9 + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr  = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [12:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o, mem_dq_i;

    int checks = 0;
    int fails  = 0;
    int clash  = 0;
    int since_rel = 100;
    int rd_age = 0;
    bit done = 0;

    logic [7:0] mem_model [int];
    logic [7:0] model_q = 8'h5A;

    always #(CLK_NS / 2) clk = ~clk;

    asram_ctrl #(
        .ADDR_W(13), .DATA_W(8), .CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(GRADE)
    ) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model: data valid only after the access-time cycles, junk otherwise.
    wire selected = !mem_ce1_n && mem_ce2;
    always @(posedge clk) begin
        if (mem_oe_n) rd_age <= 0;
        else          rd_age <= rd_age + 1;
    end
    always @(negedge clk) begin
        if (mem_model.exists(int'(mem_addr))) model_q <= mem_model[int'(mem_addr)];
        else                                  model_q <= 8'h5A;
    end
    assign mem_dq_i = (selected && mem_we_n && !mem_oe_n && rd_age >= RD_EXP - 1) ? model_q : 8'hEE;

    always @(posedge mem_we_n) begin
        if (selected && mem_dq_oe) mem_model[int'(mem_addr)] = mem_dq_o;
    end

    // Bus release monitor (R6): count cycles since output enable went high.
    always @(negedge clk) begin
        if (rst) since_rel <= 100;
        else begin
            if (!mem_oe_n) since_rel <= 0;
            else if (since_rel < 100) since_rel <= since_rel + 1;
            if (mem_dq_oe && (!mem_oe_n || since_rel + 1 <= HZ_EXP)) clash <= clash + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe} == 5'b10110, "R1",
            "idle pins", int'({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}), 5'b10110);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
    endtask

    task automatic t_idle_hold;
        int bad = 0;
        req_valid = 1'b0;
        req_addr  = 13'h1ABC;
        req_write = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready)) bad++;
        end
        chk(bad == 0, "R1", "pins stay deselected without request", bad, 0);
    endtask

    task automatic t_write(input logic [12:0] a, input logic [7:0] d);
        int we_low = 0, hold = 0, busy = 0, bad_bus = 0, oe_bad = 0;
        chk(req_ready == 1'b1, "R7", "ready before write", int'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        while (!req_ready && busy < 50) begin
            busy++;
            if (!mem_we_n) we_low++;
            else if (mem_dq_oe) hold++;
            if (mem_dq_oe && (mem_addr != a || mem_dq_o != d)) bad_bus++;
            if (!mem_oe_n) oe_bad++;
            @(negedge clk);
        end
        chk(we_low == WR_EXP, "R4", "write strobe cycles", we_low, WR_EXP);
        chk(oe_bad == 0, "R4", "output enable during write", oe_bad, 0);
        chk(hold == 1, "R5", "hold cycles after strobe", hold, 1);
        chk(bad_bus == 0, "R9", "latched address/data on pins", bad_bus, 0);
        chk(busy == WR_EXP + 1, "R7", "write busy cycles", busy, WR_EXP + 1);
        chk(mem_dq_oe == 1'b0, "R5", "driver off after write", int'(mem_dq_oe), 0);
    endtask

    task automatic t_read(input logic [12:0] a, input logic [7:0] exp);
        int oe_low = 0, busy = 0, rsp_n = 0, rsp_at = -1, bad_addr = 0, rel = 0;
        logic [7:0] got = 8'h00;
        chk(req_ready == 1'b1, "R7", "ready before read", int'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        while (!req_ready && busy < 50) begin
            busy++;
            if (!mem_oe_n) begin
                oe_low++;
                if (mem_addr != a) bad_addr++;
            end else rel++;
            if (rsp_valid) begin rsp_n++; got = rsp_rdata; rsp_at = busy; end
            @(negedge clk);
        end
        chk(oe_low == RD_EXP, "R2", "read window cycles", oe_low, RD_EXP);
        chk(rel == HZ_EXP, "R8", "release wait cycles", rel, HZ_EXP);
        chk(busy == RD_EXP + HZ_EXP, "R7", "read busy cycles", busy, RD_EXP + HZ_EXP);
        chk(rsp_n == 1 && rsp_at == RD_EXP + 1, "R3", "response pulse position", rsp_at, RD_EXP + 1);
        chk(got == exp, "R10", "read data", int'(got), int'(exp));
        chk(bad_addr == 0, "R9", "read address held", bad_addr, 0);
        chk(rsp_valid == 1'b0, "R3", "pulse ended", int'(rsp_valid), 0);
    endtask

    task automatic t_read_then_write(input logic [12:0] ra, input logic [12:0] wa, input logic [7:0] wd);
        int gap = 0, clash0;
        clash0 = clash;
        req_valid = 1'b1; req_write = 1'b0; req_addr = ra;
        @(negedge clk);
        req_write = 1'b1; req_addr = wa; req_wdata = wd;
        while (mem_we_n && gap < 50) begin
            gap++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(gap == RD_EXP + HZ_EXP + 1, "R6", "read-to-write spacing", gap, RD_EXP + HZ_EXP + 1);
        chk(clash == clash0, "R6", "driver during release window", clash - clash0, 0);
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_hold();
        t_write(13'h0000, 8'hA5);
        t_write(13'h1FFF, 8'h3C);
        t_write(13'h0555, 8'h81);
        t_read(13'h0000, 8'hA5);
        t_read(13'h1FFF, 8'h3C);
        t_read(13'h0555, 8'h81);
        t_read(13'h0777, 8'h5A);
        t_read_then_write(13'h0000, 13'h0123, 8'h7E);
        t_read(13'h0123, 8'h7E);
        t_read(13'h1FFF, 8'h3C);
        chk(clash == 0, "R6", "total release-window clashes", clash, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule